// File: doc/BRIEF.md
# Snapshot Event Counter Peripheral

This block sits on a byte-wide processor bus and keeps four running 64-bit counts: elapsed clock cycles, retired instructions, IRQ events and NMI events. Two 64-bit wall-clock values come in from outside. Software cannot see the running counts directly. A write to the snapshot register freezes all six values into shadow registers on the same clock edge.

A one-byte selector names one shadow register by a sparse code. That register then appears in an eight-byte read window. Software can collect a full 64-bit value one byte at a time, and the value cannot change between bytes while the counts keep running. The block decodes only its own ten-byte aperture, at local offsets 0x0 to 0x9.

Top module: `evt_snap_ctr`

## Requirements
- R1: On reset, every running count, every shadow register and the selector are cleared to zero. The selector then reads 0x00, and the window reads zero for every selector code until the first snapshot.
- R2: Each clock edge out of reset adds one to the cycle count. The instruction, IRQ and NMI counts each add one on every edge where their event input is high.
- R3: A write of any data value to offset 0x0 copies all six values into their shadows on that edge. The shadows receive the pre-edge running counts, so an event pulse in the same cycle is not part of that snapshot.
- R4: Between snapshot writes the shadows hold their values. Running counts and wall-clock inputs keep changing but do not reach the window.
- R5: Offset 0x1 is the selector. A write stores the data byte, and a read of offset 0x1 returns the stored byte.
- R6: Selector code 0x00 picks cycles, 0x01 instructions, 0x02 IRQ count, 0x03 NMI count, 0x80 wall time and 0x81 split wall time.
- R7: Window offset 0x2+k returns bits 8k+7:8k of the selected shadow, for k from 0 to 7. Offset 0x2 therefore gives bits 7:0 and offset 0x9 gives bits 63:56.
- R8: With any selector code other than the six in R6, every window byte reads zero.
- R9: A read of offset 0x0 returns zero, and reads of offsets 0xA to 0xF return zero. Writes to offsets 0x2 to 0xF change neither the selector nor any shadow.
- R10: While the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_off | input | 4 | Local byte offset within the aperture |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data |
| ev_insn | input | 1 | Instruction retired pulse |
| ev_irq | input | 1 | IRQ event pulse |
| ev_nmi | input | 1 | NMI event pulse |
| wall_time | input | 64 | Wall-clock value |
| wall_split | input | 64 | Split-format wall-clock value |

## Verification
The bench walks all six valid selector codes and the codes next to them (0x04, 0x7F, 0x82, 0xFF). A decoder that matched only the low bits would expose a shadow for those codes where zero is expected. It also checks all eight window bytes, so a reversed or shifted byte order shows up as mismatched bytes. A snapshot is taken in the same cycle as an IRQ pulse, and the shadow is then re-read after many running cycles with changed wall inputs. A design that captured post-edge values, or passed live counts through to the window, would show an off-by-one or a drifting value. Writes to the window and beyond the aperture, and a reset after the selector has been set, catch stray decode and an incomplete reset.

// File: rtl/evt_snap_pkg.sv
package evt_snap_pkg;

    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFF_SNAP   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_SEL    = 4'h1;
    localparam logic [ADDR_W-1:0] OFF_WIN_LO = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_WIN_HI = 4'h9;

    localparam int N_EVENT = 3;
    localparam int N_LIVE  = N_EVENT + 1;
    localparam int N_WALL  = 2;
    localparam int N_SNAP  = N_LIVE + N_WALL;

    typedef enum logic [2:0] {
        SLOT_CYC  = 3'd0,
        SLOT_INSN = 3'd1,
        SLOT_IRQ  = 3'd2,
        SLOT_NMI  = 3'd3,
        SLOT_WALL = 3'd4,
        SLOT_WSPL = 3'd5,
        SLOT_NONE = 3'd7
    } slot_e;

    typedef enum logic [BYTE_W-1:0] {
        SEL_CYC  = 8'h00,
        SEL_INSN = 8'h01,
        SEL_IRQ  = 8'h02,
        SEL_NMI  = 8'h03,
        SEL_WALL = 8'h80,
        SEL_WSPL = 8'h81
    } sel_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] off;
        logic [BYTE_W-1:0] wdata;
        logic              wr;
        logic              rd;
    } bus_req_t;

    function automatic slot_e decode_sel(input logic [BYTE_W-1:0] code);
        case (code)
            SEL_CYC:  return SLOT_CYC;
            SEL_INSN: return SLOT_INSN;
            SEL_IRQ:  return SLOT_IRQ;
            SEL_NMI:  return SLOT_NMI;
            SEL_WALL: return SLOT_WALL;
            SEL_WSPL: return SLOT_WSPL;
            default:  return SLOT_NONE;
        endcase
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] off);
        return (off >= OFF_WIN_LO) && (off <= OFF_WIN_HI);
    endfunction

endpackage

// File: rtl/evt_live_bank.sv
module evt_live_bank
    import evt_snap_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int N_EV  = N_EVENT,
    localparam int N_CNT = N_EV + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_EV-1:0]             ev,
    output logic [N_CNT-1:0][CNT_W-1:0] live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live[0] <= '0;
        end else begin
            live[0] <= live[0] + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst) begin
                live[g+1] <= '0;
            end else if (ev[g]) begin
                live[g+1] <= live[g+1] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/evt_shadow_bank.sv
module evt_shadow_bank
    import evt_snap_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int N_CNT  = N_LIVE,
    parameter int N_EXT  = N_WALL,
    localparam int N_ALL = N_CNT + N_EXT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        grab,
    input  logic [N_CNT-1:0][CNT_W-1:0] live,
    input  logic [N_EXT-1:0][CNT_W-1:0] ext,
    output logic [N_ALL-1:0][CNT_W-1:0] snap
);

    for (genvar s = 0; s < N_ALL; s++) begin : g_slot
        logic [CNT_W-1:0] src;
        if (s < N_CNT) begin : g_live
            assign src = live[s];
        end else begin : g_ext
            assign src = ext[s-N_CNT];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                snap[s] <= '0;
            end else if (grab) begin
                snap[s] <= src;
            end
        end
    end

endmodule

// File: rtl/evt_window_mux.sv
module evt_window_mux
    import evt_snap_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int N_ALL  = N_SNAP,
    localparam int WIN_B = CNT_W / BYTE_W
) (
    input  bus_req_t                    req,
    input  logic [BYTE_W-1:0]           sel,
    input  logic [N_ALL-1:0][CNT_W-1:0] snap,
    output logic [BYTE_W-1:0]           rdata
);

    slot_e            slot;
    logic [CNT_W-1:0] chosen;
    int unsigned      bidx;

    always_comb begin
        slot   = decode_sel(sel);
        chosen = '0;
        for (int s = 0; s < N_ALL; s++) begin
            if (slot != SLOT_NONE && int'(slot) == s) begin
                chosen = snap[s];
            end
        end
    end

    always_comb begin
        bidx  = 32'(req.off) - 32'(OFF_WIN_LO);
        rdata = '0;
        if (req.rd) begin
            if (req.off == OFF_SEL) begin
                rdata = sel;
            end else if (in_window(req.off) && bidx < WIN_B) begin
                rdata = chosen[bidx*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/evt_snap_ctr.sv
module evt_snap_ctr
    import evt_snap_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_off,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              ev_insn,
    input  logic              ev_irq,
    input  logic              ev_nmi,
    input  logic [CNT_W-1:0]  wall_time,
    input  logic [CNT_W-1:0]  wall_split
);

    bus_req_t                          req;
    logic [BYTE_W-1:0]                 sel_q;
    logic                              grab;
    logic [N_LIVE-1:0][CNT_W-1:0]      live;
    logic [N_WALL-1:0][CNT_W-1:0]      ext;
    logic [N_SNAP-1:0][CNT_W-1:0]      snap;

    assign req  = '{off: bus_off, wdata: bus_wdata, wr: bus_wr, rd: bus_rd};
    assign grab = req.wr && (req.off == OFF_SNAP);
    assign ext  = {wall_split, wall_time};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (req.wr && req.off == OFF_SEL) begin
            sel_q <= req.wdata;
        end
    end

    evt_live_bank #(.CNT_W(CNT_W), .N_EV(N_EVENT)) u_live (
        .clk  (clk),
        .rst  (rst),
        .ev   ({ev_nmi, ev_irq, ev_insn}),
        .live (live)
    );

    evt_shadow_bank #(.CNT_W(CNT_W), .N_CNT(N_LIVE), .N_EXT(N_WALL)) u_shadow (
        .clk  (clk),
        .rst  (rst),
        .grab (grab),
        .live (live),
        .ext  (ext),
        .snap (snap)
    );

    evt_window_mux #(.CNT_W(CNT_W), .N_ALL(N_SNAP)) u_win (
        .req   (req),
        .sel   (sel_q),
        .snap  (snap),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/evt_snap_chk.sv
module evt_snap_chk
    import evt_snap_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic                         clk,
    input logic                         rst,
    input logic [3:0]                   bus_off,
    input logic [7:0]                   bus_wdata,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [7:0]                   bus_rdata,
    input logic                         ev_irq,
    input logic [7:0]                   sel,
    input logic [N_LIVE-1:0][CNT_W-1:0] live,
    input logic [N_SNAP-1:0][CNT_W-1:0] snap
);

    a_r3_snap_copies_live: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_off == OFF_SNAP) |=> (snap[N_LIVE-1:0] == $past(live)));

    a_r4_snap_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_off == OFF_SNAP) |=> $stable(snap));

    a_r2_irq_counts: assert property (@(posedge clk) disable iff (rst)
        ev_irq |=> (live[2] == $past(live[2]) + CNT_W'(1)));

    a_r2_irq_idle: assert property (@(posedge clk) disable iff (rst)
        !ev_irq |=> $stable(live[2]));

    a_r5_sel_stores: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_off == OFF_SEL) |=> (sel == $past(bus_wdata)));

    a_r9_snap_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_off == OFF_SNAP) |-> (bus_rdata == 8'h00));

    a_r8_unknown_code_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && in_window(bus_off) && decode_sel(sel) == SLOT_NONE)
        |-> (bus_rdata == 8'h00));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

bind evt_snap_ctr evt_snap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ev_irq    (ev_irq),
    .sel       (sel_q),
    .live      (live),
    .snap      (snap)
);

// File: tb/test_evt_snap_ctr.sv
module test_evt_snap_ctr;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [7:0] code;
        logic [2:0] slot;   // 7 means no shadow: window reads zero
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h00, 3'd0}, '{8'h01, 3'd1}, '{8'h02, 3'd2}, '{8'h03, 3'd3},
        '{8'h80, 3'd4}, '{8'h81, 3'd5}, '{8'h04, 3'd7}, '{8'h7F, 3'd7},
        '{8'h82, 3'd7}, '{8'hFF, 3'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ev_insn = 1'b0;
    logic        ev_irq = 1'b0;
    logic        ev_nmi = 1'b0;
    logic [63:0] wall_time = 64'h0123_4567_89AB_CDEF;
    logic [63:0] wall_split = 64'hFEDC_BA98_7654_3210;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [63:0] m_live [4];
    logic [63:0] m_snap [6];

    evt_snap_ctr i_evt_snap_ctr (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_live[i] <= '0;
            for (int i = 0; i < 6; i++) m_snap[i] <= '0;
        end else begin
            m_live[0] <= m_live[0] + 1;
            if (ev_insn) m_live[1] <= m_live[1] + 1;
            if (ev_irq)  m_live[2] <= m_live[2] + 1;
            if (ev_nmi)  m_live[3] <= m_live[3] + 1;
            if (bus_wr && bus_off == 4'h0) begin
                for (int i = 0; i < 4; i++) m_snap[i] <= m_live[i];
                m_snap[4] <= wall_time;
                m_snap[5] <= wall_split;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_off = off; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        bus_off = off; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_win(output logic [63:0] v);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) begin
            bus_read(4'(2 + k), b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic pulse(input logic i, input logic q, input logic n);
        @(negedge clk);
        ev_insn = i; ev_irq = q; ev_nmi = n;
        @(negedge clk);
        ev_insn = 1'b0; ev_irq = 1'b0; ev_nmi = 1'b0;
    endtask

    function automatic logic [63:0] exp_of(input logic [2:0] slot);
        return (slot == 3'd7) ? 64'h0 : m_snap[slot];
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [63:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(4'h1, b);
        check("R1 selector after reset", 64'(b), 64'h0);
        bus_write(4'h1, 8'h80);
        read_win(v);
        check("R1 window before first snapshot", v, 64'h0);

        // R2: events with distinct counts
        repeat (3) pulse(1'b1, 1'b0, 1'b0);
        repeat (2) pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b1, 1'b1, 1'b1);
        repeat (4) pulse(1'b0, 1'b0, 1'b1);

        // R3: snapshot in the same cycle as an IRQ pulse
        @(negedge clk);
        bus_off = 4'h0; bus_wdata = 8'h5A; bus_wr = 1'b1; ev_irq = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_irq = 1'b0;
        bus_write(4'h1, 8'h02);
        read_win(v);
        check("R3 irq snapshot excludes same-cycle pulse", v, 64'd3);
        check("R2 irq count model", m_snap[2], 64'd3);
        check("R2 insn count model", m_snap[1], 64'd4);

        // R6/R7/R8: walk the selector table
        for (int i = 0; i < NV; i++) begin
            bus_write(4'h1, VECS[i].code);
            bus_read(4'h1, b);
            check("R5 selector readback", 64'(b), 64'(VECS[i].code));
            read_win(v);
            if (VECS[i].slot == 3'd7)
                check("R8 unassigned code reads zero", v, 64'h0);
            else
                check("R6 R7 selected shadow bytes", v, exp_of(VECS[i].slot));
        end

        // R7: byte order on the wall value
        bus_write(4'h1, 8'h80);
        bus_read(4'h2, b);
        check("R7 offset 0x2 is bits 7:0", 64'(b), 64'hEF);
        bus_read(4'h9, b);
        check("R7 offset 0x9 is bits 63:56", 64'(b), 64'h01);

        // R4: shadows hold while live values move
        bus_write(4'h1, 8'h00);
        read_win(v);
        wall_time = 64'hAAAA_5555_AAAA_5555;
        repeat (20) pulse(1'b1, 1'b1, 1'b1);
        read_win(v2);
        check("R4 cycle shadow stable", v2, v);
        bus_write(4'h1, 8'h80);
        read_win(v2);
        check("R4 wall shadow ignores new input", v2, 64'h0123_4567_89AB_CDEF);

        // R3: a fresh snapshot picks up the new values
        bus_write(4'h0, 8'h00);
        read_win(v2);
        check("R3 new wall snapshot", v2, 64'hAAAA_5555_AAAA_5555);
        bus_write(4'h1, 8'h00);
        read_win(v2);
        check("R3 new cycle snapshot", v2, m_snap[0]);

        // R9: snapshot offset and out-of-aperture reads, ignored writes
        bus_read(4'h0, b);
        check("R9 snapshot offset reads zero", 64'(b), 64'h0);
        bus_read(4'hA, b);
        check("R9 offset 0xA reads zero", 64'(b), 64'h0);
        bus_read(4'hF, b);
        check("R9 offset 0xF reads zero", 64'(b), 64'h0);
        bus_write(4'h5, 8'hFF);
        bus_write(4'hC, 8'h81);
        bus_read(4'h1, b);
        check("R9 selector untouched by stray writes", 64'(b), 64'h00);
        read_win(v);
        check("R9 shadow untouched by window write", v, m_snap[0]);

        // R10: idle read data
        @(negedge clk);
        bus_off = 4'h2;
        #1 check("R10 rdata zero without strobe", 64'(bus_rdata), 64'h0);

        // R1: reset after use
        bus_write(4'h1, 8'h81);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(4'h1, b);
        check("R1 selector cleared by reset", 64'(b), 64'h0);
        read_win(v);
        check("R1 cycle shadow cleared by reset", v, 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule